// File: doc/BRIEF.md
# Disk Task-File Host Register Port

This block is the host-side register window of a disk controller. A processor reaches it through an 8-bit data bus, an address and separate read and write strobes. Eight byte-wide registers sit behind the low three address bits. A downstream command engine reads the command parameters from the block's output pins.

Two writes have side effects. Writing the drive/head register also selects one of four drives. Writing the command register latches the current cylinder pair and the sector count into state kept for the selected drive, and raises a one-cycle command strobe. The command byte, selected drive, head, sector number and the latched cylinder and count of the selected drive are always present on the outputs. Media access, interrupts and data buffering belong to other blocks.

Top module: `atf_host_regs`

## Requirements
- R1: A synchronous active-high reset clears all eight registers, selects drive 0, clears the latched cylinder and count of every drive, and holds `cmd_valid` low.
- R2: A write to register index 0 to 6 stores the byte unchanged. The next read at that index returns it. Index 0 is data, 1 error, 2 sector count, 3 sector number, 4 cylinder low, 5 cylinder high, 6 drive/head, 7 command.
- R3: Address bits above bit 2 are ignored for both writes and reads.
- R4: A write to index 6 selects drive number wdata[4:3], which appears on `cmd_drive` from the cycle after the write.
- R5: `cmd_head` always shows bits [2:0] of register 6, and `cmd_sector` always shows register 3.
- R6: A write to index 7 loads the selected drive's cylinder with {register 5, register 4} and its count with register 2. The registers used are the values present before that write. No other drive's state changes. `cmd_cyl` and `cmd_count` show the state of the currently selected drive.
- R7: Each write to index 7 makes `cmd_valid` high for exactly the following cycle. Back-to-back command writes give back-to-back pulses. `cmd_code` shows register 7.
- R8: With `bus_rd` high, `bus_rdata` combinationally returns the stored byte of the addressed register. With `bus_rd` low it is 0.
- R9: The byte written to index 7 is stored and reads back at index 7.
- R10: After a command, changes to registers 2, 4 and 5 do not alter `cmd_cyl` or `cmd_count` until the next command write for that drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register address; only bits [2:0] decode |
| bus_wdata | input | DATA_W | Write data |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Read data, 0 when not reading |
| cmd_valid | output | 1 | One-cycle pulse after a command write |
| cmd_code | output | DATA_W | Command register contents |
| cmd_drive | output | DRV_W | Selected drive |
| cmd_head | output | 3 | Head from drive/head register |
| cmd_sector | output | DATA_W | Sector number register |
| cmd_cyl | output | 2*DATA_W | Latched cylinder of the selected drive |
| cmd_count | output | DATA_W | Latched count of the selected drive |

## Verification
The bench targets addresses with nonzero upper bits. A decoder that used them would write the wrong register or read zeros. Per-drive isolation is checked by switching drives between commands and reading the other drives' state back through `cmd_cyl`. A design that wrote every drive, or the wrong one, would show a stale or foreign cylinder there. Back-to-back command writes expose a pulse generator that merges strobes. Changing the cylinder registers after a command catches outputs wired to the live registers instead of the latched state.

// File: rtl/atf_pkg.sv
package atf_pkg;
    // register indices; the command engine and drive logic depend on these
    localparam int unsigned IDX_W       = 3;
    localparam int unsigned NUM_REGS    = 1 << IDX_W;
    localparam logic [IDX_W-1:0] IX_COUNT  = 3'd2;
    localparam logic [IDX_W-1:0] IX_SECTOR = 3'd3;
    localparam logic [IDX_W-1:0] IX_CYL_LO = 3'd4;
    localparam logic [IDX_W-1:0] IX_CYL_HI = 3'd5;
    localparam logic [IDX_W-1:0] IX_DRVHD  = 3'd6;
    localparam logic [IDX_W-1:0] IX_CMD    = 3'd7;

    // drive/head register field positions
    localparam int unsigned HEAD_LSB  = 0;
    localparam int unsigned HEAD_W    = 3;
    localparam int unsigned DRSEL_LSB = 3;

    typedef logic [IDX_W-1:0] reg_idx_t;
endpackage

// File: rtl/atf_reg_bank.sv
module atf_reg_bank
    import atf_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DRV_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_i,
    input  reg_idx_t          idx_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] regs_o [NUM_REGS],
    output logic [DRV_W-1:0]  drive_o,
    output logic              cmd_fire_o
);
    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0] regs;
        logic [DRV_W-1:0]                drive;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            st_d.regs[idx_i] = wdata_i;
            if (idx_i == IX_DRVHD) begin
                st_d.drive = wdata_i[DRSEL_LSB +: DRV_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_out
        assign regs_o[g] = st_q.regs[g];
    end
    assign drive_o    = st_q.drive;
    assign cmd_fire_o = wr_i && (idx_i == IX_CMD);

    // R2 R9
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_chk
        reg_store_chk: assert property (@(posedge clk) disable iff (rst)
            (wr_i && idx_i == reg_idx_t'(g)) |=> (regs_o[g] == $past(wdata_i)));
    end

    // R4
    drive_sel_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_i && idx_i == IX_DRVHD) |=> (drive_o == $past(wdata_i[DRSEL_LSB +: DRV_W])));
endmodule

// File: rtl/atf_drive_table.sv
module atf_drive_table #(
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned NUM_DRIVES = 4,
    parameter int unsigned DRV_W      = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load_i,
    input  logic [DRV_W-1:0]    load_drive_i,
    input  logic [2*DATA_W-1:0] cyl_i,
    input  logic [DATA_W-1:0]   cnt_i,
    input  logic [DRV_W-1:0]    view_drive_i,
    output logic [2*DATA_W-1:0] view_cyl_o,
    output logic [DATA_W-1:0]   view_cnt_o
);
    localparam int unsigned CYL_W = 2 * DATA_W;

    typedef struct packed {
        logic [NUM_DRIVES-1:0][CYL_W-1:0]  trk;
        logic [NUM_DRIVES-1:0][DATA_W-1:0] cnt;
    } tbl_t;

    tbl_t tb_d, tb_q;
    logic [NUM_DRIVES-1:0] hit;

    for (genvar g = 0; g < NUM_DRIVES; g++) begin : g_hit
        assign hit[g] = load_i && (load_drive_i == DRV_W'(g));
    end

    always_comb begin
        tb_d = tb_q;
        for (int i = 0; i < NUM_DRIVES; i++) begin
            if (hit[i]) begin
                tb_d.trk[i] = cyl_i;
                tb_d.cnt[i] = cnt_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tb_q <= '0;
        end else begin
            tb_q <= tb_d;
        end
    end

    assign view_cyl_o = tb_q.trk[view_drive_i];
    assign view_cnt_o = tb_q.cnt[view_drive_i];

    // R6
    load_once_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(hit));

    for (genvar g = 0; g < NUM_DRIVES; g++) begin : g_chk
        // R6
        slot_load_chk: assert property (@(posedge clk) disable iff (rst)
            hit[g] |=> (tb_q.trk[g] == $past(cyl_i) && tb_q.cnt[g] == $past(cnt_i)));
        // R6 R10
        slot_hold_chk: assert property (@(posedge clk) disable iff (rst)
            !hit[g] |=> ($stable(tb_q.trk[g]) && $stable(tb_q.cnt[g])));
    end
endmodule

// File: rtl/atf_cmd_strobe.sv
module atf_cmd_strobe (
    input  logic clk,
    input  logic rst,
    input  logic fire_i,
    output logic valid_o
);
    logic valid_d, valid_q;

    always_comb begin
        valid_d = fire_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
        end else begin
            valid_q <= valid_d;
        end
    end

    assign valid_o = valid_q;

    // R7
    pulse_src_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> $past(fire_i));
endmodule

// File: rtl/atf_host_regs.sv
module atf_host_regs
    import atf_pkg::*;
#(
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned NUM_DRIVES = 4,
    parameter int unsigned DRV_W      = $clog2(NUM_DRIVES)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic                bus_wr,
    input  logic                bus_rd,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                cmd_valid,
    output logic [DATA_W-1:0]   cmd_code,
    output logic [DRV_W-1:0]    cmd_drive,
    output logic [2:0]          cmd_head,
    output logic [DATA_W-1:0]   cmd_sector,
    output logic [2*DATA_W-1:0] cmd_cyl,
    output logic [DATA_W-1:0]   cmd_count
);
    reg_idx_t          idx;
    logic [DATA_W-1:0] regs [NUM_REGS];
    logic [DRV_W-1:0]  drive;
    logic              fire;

    assign idx = bus_addr[IDX_W-1:0];

    atf_reg_bank #(.DATA_W(DATA_W), .DRV_W(DRV_W)) u_bank (
        .clk        (clk),
        .rst        (rst),
        .wr_i       (bus_wr),
        .idx_i      (idx),
        .wdata_i    (bus_wdata),
        .regs_o     (regs),
        .drive_o    (drive),
        .cmd_fire_o (fire)
    );

    atf_drive_table #(.DATA_W(DATA_W), .NUM_DRIVES(NUM_DRIVES), .DRV_W(DRV_W)) u_table (
        .clk          (clk),
        .rst          (rst),
        .load_i       (fire),
        .load_drive_i (drive),
        .cyl_i        ({regs[IX_CYL_HI], regs[IX_CYL_LO]}),
        .cnt_i        (regs[IX_COUNT]),
        .view_drive_i (drive),
        .view_cyl_o   (cmd_cyl),
        .view_cnt_o   (cmd_count)
    );

    atf_cmd_strobe u_strobe (
        .clk     (clk),
        .rst     (rst),
        .fire_i  (fire),
        .valid_o (cmd_valid)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            bus_rdata = regs[idx];
        end
    end

    assign cmd_code   = regs[IX_CMD];
    assign cmd_drive  = drive;
    assign cmd_head   = regs[IX_DRVHD][HEAD_LSB +: HEAD_W];
    assign cmd_sector = regs[IX_SECTOR];

    // R8
    idle_read_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |-> (bus_rdata == '0));

    // R7
    cmd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr[2:0] == 3'd7) |=> cmd_valid);
endmodule

// File: tb/atf_host_regs_bench.sv
module atf_host_regs_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic        cmd_valid;
    logic [7:0]  cmd_code;
    logic [1:0]  cmd_drive;
    logic [2:0]  cmd_head;
    logic [7:0]  cmd_sector;
    logic [15:0] cmd_cyl;
    logic [7:0]  cmd_count;

    atf_host_regs u_atf_host_regs (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_drive(cmd_drive),
        .cmd_head(cmd_head), .cmd_sector(cmd_sector), .cmd_cyl(cmd_cyl),
        .cmd_count(cmd_count)
    );

    always #5 clk = ~clk;

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    string phase  = "R1";

    // behavioural reference
    int m_reg [8];
    int m_trk [4];
    int m_cnt [4];
    int m_sel   = 0;
    int m_valid = 0;

    initial begin
        for (int i = 0; i < 8; i++) m_reg[i] = 0;
        for (int i = 0; i < 4; i++) begin m_trk[i] = 0; m_cnt[i] = 0; end
    end

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 8; i++) m_reg[i] = 0;
            for (int i = 0; i < 4; i++) begin m_trk[i] = 0; m_cnt[i] = 0; end
            m_sel = 0;
            m_valid = 0;
        end else begin
            int a;
            a = bus_addr % 8;
            m_valid = (bus_wr && a == 7) ? 1 : 0;
            if (bus_wr) begin
                if (a == 7) begin
                    m_trk[m_sel] = m_reg[5] * 256 + m_reg[4];
                    m_cnt[m_sel] = m_reg[2];
                end
                m_reg[a] = bus_wdata;
                if (a == 6) m_sel = (bus_wdata / 8) % 4;
            end
        end
    end

    task automatic chk(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", phase, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            chk("rdata",  int'(bus_rdata), bus_rd ? m_reg[bus_addr % 8] : 0);
            chk("valid",  int'(cmd_valid), m_valid);
            chk("code",   int'(cmd_code), m_reg[7]);
            chk("drive",  int'(cmd_drive), m_sel);
            chk("head",   int'(cmd_head), m_reg[6] % 8);
            chk("sector", int'(cmd_sector), m_reg[3]);
            chk("cyl",    int'(cmd_cyl), m_trk[m_sel]);
            chk("count",  int'(cmd_count), m_cnt[m_sel]);
        end
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired in phase %s", phase);
            finish_run();
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr(int addr, int data);
        step();
        bus_wr = 1'b1; bus_rd = 1'b0;
        bus_addr = 8'(addr); bus_wdata = 8'(data);
        step();
        bus_wr = 1'b0;
    endtask

    task automatic wr_b2b(int addr, int data);
        step();
        bus_wr = 1'b1; bus_rd = 1'b0;
        bus_addr = 8'(addr); bus_wdata = 8'(data);
    endtask

    task automatic rd(int addr);
        step();
        bus_wr = 1'b0; bus_rd = 1'b1; bus_addr = 8'(addr);
        step();
        bus_rd = 1'b0;
    endtask

    task automatic do_reset();
        step();
        rst = 1'b1; bus_wr = 1'b0; bus_rd = 1'b0;
        step(); step();
        rst = 1'b0;
    endtask

    initial begin
        // R1: reset state
        phase = "R1";
        do_reset();
        for (int i = 0; i < 8; i++) rd(i);

        // R2: plain stores at indices 0..6
        phase = "R2";
        for (int i = 0; i < 7; i++) wr(i, 8'h31 + i * 8'h17);
        for (int i = 0; i < 7; i++) rd(i);

        // R3: upper address bits ignored
        phase = "R3";
        wr(8'hAB, 8'h5C);
        rd(8'hF3);
        rd(8'h03);
        wr(8'h3A, 8'h99);
        rd(8'h02);

        // R4, R5: drive and head selection
        phase = "R4";
        wr(6, 8'h1D);
        rd(6);
        wr(6, 8'h08);
        phase = "R5";
        wr(6, 8'h16);
        wr(3, 8'h44);

        // R6: command latches into selected drive only
        phase = "R6";
        wr(6, 8'h18);
        wr(4, 8'h34); wr(5, 8'h12); wr(2, 8'h07);
        wr(7, 8'h20);
        wr(6, 8'h08);
        wr(4, 8'hF0); wr(5, 8'h00); wr(2, 8'h03);
        wr(7, 8'h30);
        wr(6, 8'h00);
        wr(6, 8'h10);
        wr(6, 8'h18);

        // R10: later register changes do not disturb latched state
        phase = "R10";
        wr(4, 8'hAA); wr(5, 8'hBB); wr(2, 8'hCC);
        rd(4);

        // R7: back-to-back command pulses, command byte shown
        phase = "R7";
        wr_b2b(7, 8'hC1);
        wr_b2b(7, 8'hC2);
        wr_b2b(8'hF7, 8'hC3);
        step();
        bus_wr = 1'b0;
        step(); step();

        // R9: command byte readback
        phase = "R9";
        rd(7);
        rd(8'h1F);

        // R8: strobe low gives zero even when addressed
        phase = "R8";
        step();
        bus_addr = 8'h04;
        step(); step();
        rd(4);

        // R1: reset again clears everything
        phase = "R1";
        do_reset();
        for (int i = 0; i < 8; i++) rd(i);
        step(); step();
        finish_run();
    end
endmodule